// File: doc/BRIEF.md
# Packed SIMD Averaging Unit

This unit takes two packed operands and produces, lane by lane, the unsigned average of the matching lanes. A mode input picks the lane size. In narrow mode the operand splits into byte lanes. In wide mode it splits into halfword lanes, each two bytes wide. A single rounding bit is added to every lane sum before the sum is halved. The sum keeps its carry bit, so the average never wraps.

With each result the unit also produces a status word for a SIMD flag register. The word holds four flag bits per byte position, in the order N, Z, C, V from the most significant bit down. Only the Z bit is ever written. In wide mode each halfword lane reports its Z bit in the upper of the two nibbles that its bytes own.

The result and the flag word are registered. A valid strobe follows the input strobe by one cycle. Cycles without an input strobe leave the outputs unchanged.

Top module: `avg_simd_unit`

## Requirements
- R1: With `half_mode`=0, each byte lane k of `avg_out` (bits 8k+7..8k) equals (a_k + b_k + `round_up`) >> 1. The sum is formed with 9 bits, so the carry becomes bit 7 of the lane and never enters the neighbouring lane.
- R2: With `half_mode`=1, each halfword lane j (bits 16j+15..16j) equals (a_j + b_j + `round_up`) >> 1. The sum is formed with 17 bits, and the carry between the two bytes of the lane is propagated.
- R3: `round_up` is a single bit added equally to every lane. Toggling it changes a lane's result by at most one, and only where the lane sum is odd or rounds up.
- R4: With `half_mode`=0, flag nibble k occupies `lane_flags` bits 4k+3..4k. Its Z bit (bit 4k+2) is 1 exactly when byte lane k of `avg_out` is zero.
- R5: With `half_mode`=1, the Z flag of halfword lane j is bit 8j+6 of `lane_flags`, which is the Z position of the upper nibble of that lane's slot. All bits of the lower nibble of each slot are 0.
- R6: The N, C and V positions (bits 4k+3, 4k+1 and 4k of every nibble) are always 0.
- R7: `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid`=1 and is 0 otherwise. `avg_out` and `lane_flags` change at that same edge.
- R8: An edge that samples `in_valid`=0 leaves `avg_out` and `lane_flags` unchanged, whatever values the operands carry.
- R9: A clock edge with `rst`=1 clears `out_valid`, `avg_out` and `lane_flags` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| half_mode | input | 1 | 0: byte lanes, 1: halfword lanes |
| round_up | input | 1 | Rounding bit added to every lane sum |
| opnd_a | input | DATA_W | First packed operand |
| opnd_b | input | DATA_W | Second packed operand |
| out_valid | output | 1 | Result registered from an accepted input |
| avg_out | output | DATA_W | Packed lane averages |
| lane_flags | output | 4*DATA_W/8 | Per-lane flag nibbles (N,Z,C,V), Z only |

## Verification
The bench builds the unit with DATA_W=16, which gives two byte lanes or one halfword lane. At this width every byte pair can be swept through both lanes under both rounding values, with one vector per cycle. That covers all carry and zero cases in narrow mode, including a carry in lane 0 beside a zero in lane 1. Wide mode is swept over a 64 by 64 grid of spread halfword values, plus corner pairs (all-zero, all-ones, sign-bit carry, round-to-zero). These exercise the carry from the low byte into the high byte and the placement of the flag in the upper nibble.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int FLAG_NIB_W = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  typedef enum logic {
    LANE_NARROW = 1'b0,
    LANE_WIDE   = 1'b1
  } lane_mode_e;

  function automatic logic [FLAG_NIB_W-1:0] z_nibble(input logic z);
    logic [FLAG_NIB_W-1:0] n;
    n = '0;
    n[FLG_Z] = z;
    return n;
  endfunction
endpackage

// File: rtl/avg_chunk.sv
module avg_chunk #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-2:0] upper,
  output logic         lsb,
  output logic         cout
);
  logic [W:0] sum;

  assign sum   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign upper = sum[W-1:1];
  assign lsb   = sum[0];
  assign cout  = sum[W];
endmodule

// File: rtl/avg_datapath.sv
module avg_datapath
  import avg_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8,
  parameter int GROUP   = 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              rnd,
  input  lane_mode_e        mode,
  output logic [DATA_W-1:0] res
);
  localparam int NCH = DATA_W / CHUNK_W;

  logic [NCH-1:0]     cin;
  logic [NCH-1:0]     lsb;
  logic [NCH-1:0]     cout;
  logic [NCH-1:0]     top;
  logic [CHUNK_W-2:0] upper [NCH];
  logic               wide;

  assign wide = (mode == LANE_WIDE);

  for (genvar i = 0; i < NCH; i++) begin : g_chunk
    avg_chunk #(.W(CHUNK_W)) u_chunk (
      .a    (a[i*CHUNK_W +: CHUNK_W]),
      .b    (b[i*CHUNK_W +: CHUNK_W]),
      .cin  (cin[i]),
      .upper(upper[i]),
      .lsb  (lsb[i]),
      .cout (cout[i])
    );

    // carry into a chunk: rounding bit at a lane start, neighbour carry inside a wide lane
    if (i % GROUP == 0) begin : g_start
      assign cin[i] = rnd;
    end else begin : g_inner
      assign cin[i] = wide ? cout[i-1] : rnd;
    end

    // top bit of halved chunk: own carry at a lane end, next chunk's lsb inside a wide lane
    if ((i == NCH-1) || (i % GROUP == GROUP-1)) begin : g_end
      assign top[i] = cout[i];
    end else begin : g_mid
      assign top[i] = wide ? lsb[i+1] : cout[i];
    end

    assign res[i*CHUNK_W +: CHUNK_W] = {top[i], upper[i]};
  end
endmodule

// File: rtl/avg_flags.sv
module avg_flags
  import avg_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8,
  parameter int GROUP   = 2
) (
  input  logic [DATA_W-1:0]                   res,
  input  lane_mode_e                          mode,
  output logic [FLAG_NIB_W*DATA_W/CHUNK_W-1:0] flags
);
  localparam int NCH = DATA_W / CHUNK_W;
  localparam int NGR = NCH / GROUP;

  logic [NCH-1:0] zc;
  logic [NGR-1:0] zg;
  logic [NCH-1:0] zsel;
  logic           wide;

  assign wide = (mode == LANE_WIDE);

  for (genvar i = 0; i < NCH; i++) begin : g_cz
    assign zc[i] = ~|res[i*CHUNK_W +: CHUNK_W];
  end

  for (genvar g = 0; g < NGR; g++) begin : g_gz
    assign zg[g] = &zc[g*GROUP +: GROUP];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_nib
    if (i % GROUP == GROUP-1) begin : g_hi
      assign zsel[i] = wide ? zg[i/GROUP] : zc[i];
    end else begin : g_lo
      assign zsel[i] = wide ? 1'b0 : zc[i];
    end
    assign flags[i*FLAG_NIB_W +: FLAG_NIB_W] = z_nibble(zsel[i]);
  end
endmodule

// File: rtl/avg_simd_unit.sv
module avg_simd_unit
  import avg_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8,
  parameter int GROUP   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic                                 half_mode,
  input  logic                                 round_up,
  input  logic [DATA_W-1:0]                    opnd_a,
  input  logic [DATA_W-1:0]                    opnd_b,
  output logic                                 out_valid,
  output logic [DATA_W-1:0]                    avg_out,
  output logic [FLAG_NIB_W*DATA_W/CHUNK_W-1:0] lane_flags
);
  localparam int NCH    = DATA_W / CHUNK_W;
  localparam int FLAG_W = FLAG_NIB_W * NCH;
  localparam int WIDE_W = CHUNK_W * GROUP;
  localparam int NGR    = NCH / GROUP;

  lane_mode_e          mode;
  logic [DATA_W-1:0]   res_d;
  logic [FLAG_W-1:0]   flg_d;

  assign mode = half_mode ? LANE_WIDE : LANE_NARROW;

  avg_datapath #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W), .GROUP(GROUP)) u_dp (
    .a   (opnd_a),
    .b   (opnd_b),
    .rnd (round_up),
    .mode(mode),
    .res (res_d)
  );

  avg_flags #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W), .GROUP(GROUP)) u_flg (
    .res  (res_d),
    .mode (mode),
    .flags(flg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      avg_out    <= '0;
      lane_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        avg_out    <= res_d;
        lane_flags <= flg_d;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(avg_out) && $stable(lane_flags))); // R8

  for (genvar i = 0; i < NCH; i++) begin : g_chk_nib
    AST_NCV_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (!lane_flags[i*FLAG_NIB_W+FLG_N] && !lane_flags[i*FLAG_NIB_W+FLG_C]
       && !lane_flags[i*FLAG_NIB_W+FLG_V])); // R6
    AST_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !$past(half_mode)) |->
        (lane_flags[i*FLAG_NIB_W+FLG_Z] == (avg_out[i*CHUNK_W +: CHUNK_W] == '0))); // R4
  end

  for (genvar g = 0; g < NGR; g++) begin : g_chk_wide
    AST_WIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(half_mode)) |->
        (lane_flags[((g+1)*GROUP-1)*FLAG_NIB_W+FLG_Z] ==
         (avg_out[g*WIDE_W +: WIDE_W] == '0))); // R5
  end
endmodule

// File: tb/avg_simd_unit_tb.sv
module avg_simd_unit_tb;
  localparam int DW = 16;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          half_mode;
  logic          round_up;
  logic [DW-1:0] opnd_a;
  logic [DW-1:0] opnd_b;
  logic          out_valid;
  logic [DW-1:0] avg_out;
  logic [FW-1:0] lane_flags;

  always #4 clk = ~clk;

  avg_simd_unit #(.DATA_W(DW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .half_mode (half_mode),
    .round_up  (round_up),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .avg_out   (avg_out),
    .lane_flags(lane_flags)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic          pend = 1'b0;
  logic [DW-1:0] exp_r;
  logic [FW-1:0] exp_f;
  string         tag_r;
  string         tag_f;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference from the requirement text: lane = (a+b+r)>>1 ; Z at 4k+2 (byte) or 8j+6 (half)
  task automatic model(input logic wide, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic r, output logic [DW-1:0] res, output logic [FW-1:0] flg);
    int lw;
    int mask;
    res = '0;
    flg = '0;
    lw = wide ? 16 : 8;
    mask = (1 << lw) - 1;
    for (int l = 0; l < DW / lw; l++) begin
      int av;
      int bv;
      int s;
      int rl;
      av = (int'(a) >> (l * lw)) & mask;
      bv = (int'(b) >> (l * lw)) & mask;
      s = av + bv + int'(r);
      rl = (s >> 1) & mask;
      res = res | DW'(rl << (l * lw));
      if (rl == 0) begin
        if (wide) flg[8*l+6] = 1'b1;
        else      flg[4*l+2] = 1'b1;
      end
    end
  endtask

  task automatic step(input logic wide, input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic r);
    @(negedge clk);
    if (pend) begin
      chk(tag_r, 32'(avg_out), 32'(exp_r));
      chk(tag_f, 32'(lane_flags), 32'(exp_f));
    end
    in_valid  = 1'b1;
    half_mode = wide;
    round_up  = r;
    opnd_a    = a;
    opnd_b    = b;
    model(wide, a, b, r, exp_r, exp_f);
    tag_r = wide ? "R2/R3 wide result" : "R1/R3 byte result";
    tag_f = wide ? "R5/R6 wide flags" : "R4/R6 byte flags";
    pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    chk("R7 valid after strobe", 32'(out_valid), 32'd1);
    chk(tag_r, 32'(avg_out), 32'(exp_r));
    chk(tag_f, 32'(lane_flags), 32'(exp_f));
    in_valid = 1'b0;
    pend = 1'b0;
    @(negedge clk);
    chk("R7 valid drops", 32'(out_valid), 32'd0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst       = 1'b1;
    in_valid  = 1'b1;
    half_mode = 1'b0;
    round_up  = 1'b1;
    opnd_a    = 16'hF0F0;
    opnd_b    = 16'h1234;
    repeat (2) @(negedge clk);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    chk("R9 reset avg_out", 32'(avg_out), 32'd0);
    chk("R9 reset lane_flags", 32'(lane_flags), 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // narrow mode: every byte pair in lane 0, a permuted pair in lane 1, both rounding values
    for (int r = 0; r < 2; r++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          step(1'b0, {8'(x ^ 8'hA5), 8'(x)}, {8'(255 - y), 8'(y)}, 1'(r));
        end
      end
    end
    flush();

    // R8: operands change with in_valid low; outputs must hold the last result
    for (int k = 0; k < 3; k++) begin
      half_mode = 1'(k);
      round_up  = 1'b1;
      opnd_a    = 16'h1357 + 16'(k);
      opnd_b    = 16'hFFFF;
      @(negedge clk);
      chk("R8 hold avg_out", 32'(avg_out), 32'(exp_r));
      chk("R8 hold lane_flags", 32'(lane_flags), 32'(exp_f));
      chk("R7 no strobe no valid", 32'(out_valid), 32'd0);
    end

    // wide mode corners: zero, all-ones, top-bit carry, round toward zero and one
    step(1'b1, 16'h0000, 16'h0000, 1'b0);
    step(1'b1, 16'hFFFF, 16'hFFFF, 1'b1);
    step(1'b1, 16'h8000, 16'h8000, 1'b0);
    step(1'b1, 16'h0000, 16'h0001, 1'b0);
    step(1'b1, 16'h0000, 16'h0001, 1'b1);
    step(1'b1, 16'h00FF, 16'h0001, 1'b0);
    step(1'b1, 16'h00FF, 16'h00FF, 1'b1);
    // wide mode grid of spread values
    for (int r = 0; r < 2; r++) begin
      for (int x = 0; x < 64; x++) begin
        for (int y = 0; y < 64; y++) begin
          step(1'b1, 16'(x * 1041), 16'(16'hFFFF - y * 1039), 1'(r));
        end
      end
    end
    // mode switching back to back
    step(1'b0, 16'h0100, 16'h0100, 1'b0);
    step(1'b1, 16'h0100, 16'h0100, 1'b0);
    step(1'b0, 16'h00FF, 16'h0001, 1'b1);
    flush();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule